// File: doc/BRIEF.md
# Counter-Compare PWM Channel with Buffered Reload

This block is a single pulse-width channel built around a free-running W-bit timebase count. The count advances by one on every cycle where a count-enable strobe is high and rolls from its all-ones value back to zero. The output rises in the cycle the count reaches an active compare byte and falls when the count rolls over. A shadow compare byte is copied into the active byte at every rollover. Software can therefore change the duty at any time, and each period is still produced whole from one compare value.

A small write/read register port holds a two-bit mode register, the active byte and the shadow byte. Writing the active byte disarms the comparator and writing the shadow byte arms it again. Clearing the compare-enable bit holds the output low, which is how a 0% duty is produced. With both enable bits set, the duty over one period is (2^W − shadow) / 2^W. A shadow value of 0 gives a constant high output.

The output stage is a two-state machine. `OUT_LOW` moves to `OUT_HIGH` on the SET transition: the channel is armed, the strobe is high and the next count equals the compare target. `OUT_HIGH` returns to `OUT_LOW` on the CLEAR transition, which is a rollover with no match in the same cycle. It also returns to `OUT_LOW` on the DISARM transition, when either enable bit is 0. In every other case the state holds. During a rollover cycle the compare target is the shadow byte, because that is the value being reloaded. All other cycles compare against the active byte.

Top module: `cmp_pwm_channel`

## Requirements
- R1: After reset the count, the output, the active byte, the shadow byte and both mode bits are 0.
- R2: The count increases by exactly one, modulo 2^W, on each clock edge where `tick` is 1 and keeps its value when `tick` is 0.
- R3: When armed (both enable bits 1), the output becomes 1 at the edge where the count steps onto the compare target, so it is high for count values from the active byte up to all-ones.
- R4: The output becomes 0 at the edge where the count rolls from all-ones to 0, unless R6 applies.
- R5: At every rollover the active byte is loaded from the shadow byte. A shadow write in the middle of a period changes the duty only from the next period onward.
- R6: When the shadow byte is 0, the match at the rollover takes priority over the clear, and the output stays high for the whole period (100% duty).
- R7: A bus write to the active byte (address 1) forces compare-enable to 0. A bus write to the shadow byte (address 2) forces compare-enable to 1.
- R8: Unless compare-enable and PWM-enable are both 1, the output is 0 at the next edge (0% duty).
- R9: Counted in ticks over a full period of 256 ticks, the output is high for 256 − shadow ticks: 256 for 0, 255 for 1, 128 for 0x80, and 1 for 0xFF.
- R10: Address map: 0 = mode (bit 0 compare-enable, bit 1 PWM-enable); 1 = active byte; 2 = shadow byte; 3 = count, read-only, where writes have no effect. `rd_data` returns the addressed value combinationally.
- R11: A bus write to the active byte in the same cycle as a rollover wins over the reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable strobe for the timebase |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | W | Read data for `rd_addr` |
| count_o | output | W | Current timebase count |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds the block with its default width W = 8. This gives the full 256-tick period, so the exact duties for shadow values 0, 1, 0x80 and 0xFF can be counted tick by tick against the requirement formula. At this width the all-ones rollover is also reached often enough to test a mid-period shadow write, a write to the active byte in the same cycle as a rollover, and gated strobe patterns, all within a short run.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic [1:0] {
        ADDR_MODE   = 2'd0,
        ADDR_ACTIVE = 2'd1,
        ADDR_SHADOW = 2'd2,
        ADDR_COUNT  = 2'd3
    } cpwm_addr_e;

    typedef enum logic {
        OUT_LOW  = 1'b0,
        OUT_HIGH = 1'b1
    } cpwm_state_e;

    localparam int MODE_CMP_BIT = 0;
    localparam int MODE_PWM_BIT = 1;

endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic [W-1:0] next_count,
    output logic         wrap
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    assign next_count = count + {{(W-1){1'b0}}, 1'b1};
    assign wrap       = tick && (count == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (tick) begin
            count <= next_count;
        end
    end
endmodule

// File: rtl/cpwm_regs.sv
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_addr,
    input  logic         wrap,
    input  logic [W-1:0] count,
    output logic [W-1:0] active_q,
    output logic [W-1:0] shadow_q,
    output logic         cmp_en_q,
    output logic         pwm_en_q,
    output logic [W-1:0] rd_data
);
    cpwm_addr_e wsel;
    cpwm_addr_e rsel;
    logic       wr_mode, wr_act, wr_shd;

    assign wsel    = cpwm_addr_e'(wr_addr);
    assign rsel    = cpwm_addr_e'(rd_addr);
    assign wr_mode = wr_en && (wsel == ADDR_MODE);
    assign wr_act  = wr_en && (wsel == ADDR_ACTIVE);
    assign wr_shd  = wr_en && (wsel == ADDR_SHADOW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= '0;
            shadow_q <= '0;
            cmp_en_q <= 1'b0;
            pwm_en_q <= 1'b0;
        end else begin
            if (wr_act) begin
                active_q <= wr_data;
            end else if (wrap) begin
                active_q <= shadow_q;
            end
            if (wr_shd) begin
                shadow_q <= wr_data;
            end
            if (wr_mode) begin
                cmp_en_q <= wr_data[MODE_CMP_BIT];
                pwm_en_q <= wr_data[MODE_PWM_BIT];
            end else if (wr_act) begin
                cmp_en_q <= 1'b0;
            end else if (wr_shd) begin
                cmp_en_q <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (rsel)
            ADDR_MODE:   rd_data = {{(W-2){1'b0}}, pwm_en_q, cmp_en_q};
            ADDR_ACTIVE: rd_data = active_q;
            ADDR_SHADOW: rd_data = shadow_q;
            ADDR_COUNT:  rd_data = count;
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cpwm_out_fsm.sv
module cpwm_out_fsm
    import cpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wrap,
    input  logic [W-1:0] next_count,
    input  logic [W-1:0] active_q,
    input  logic [W-1:0] shadow_q,
    input  logic         cmp_en_q,
    input  logic         pwm_en_q,
    output logic         pwm_o
);
    cpwm_state_e state_q, state_d;
    logic [W-1:0] target;
    logic         armed, hit;

    assign armed  = cmp_en_q && pwm_en_q;
    assign target = wrap ? shadow_q : active_q;
    assign hit    = tick && (next_count == target);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_LOW: begin
                if (armed && hit) begin
                    state_d = OUT_HIGH;
                end
            end
            OUT_HIGH: begin
                if (!armed) begin
                    state_d = OUT_LOW;
                end else if (wrap && !hit) begin
                    state_d = OUT_LOW;
                end
            end
            default: state_d = OUT_LOW;
        endcase
    end

    always_comb begin
        pwm_o = (state_q == OUT_HIGH);
    end
endmodule

// File: rtl/cmp_pwm_channel.sv
module cmp_pwm_channel #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_addr,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] count_o,
    output logic         pwm_o
);
    logic [W-1:0] count_q, next_count;
    logic         wrap;
    logic [W-1:0] active_q, shadow_q;
    logic         cmp_en_q, pwm_en_q;

    cpwm_timebase #(.W(W)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .count      (count_q),
        .next_count (next_count),
        .wrap       (wrap)
    );

    cpwm_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .wrap     (wrap),
        .count    (count_q),
        .active_q (active_q),
        .shadow_q (shadow_q),
        .cmp_en_q (cmp_en_q),
        .pwm_en_q (pwm_en_q),
        .rd_data  (rd_data)
    );

    cpwm_out_fsm #(.W(W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .wrap       (wrap),
        .next_count (next_count),
        .active_q   (active_q),
        .shadow_q   (shadow_q),
        .cmp_en_q   (cmp_en_q),
        .pwm_en_q   (pwm_en_q),
        .pwm_o      (pwm_o)
    );

    assign count_o = count_q;
endmodule

// File: rtl/cpwm_channel_chk.sv
module cpwm_channel_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         wr_en,
    input logic [1:0]   wr_addr,
    input logic [W-1:0] count,
    input logic [W-1:0] active,
    input logic [W-1:0] shadow,
    input logic         cmp_en,
    input logic         pwm_en,
    input logic         pwm_o
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count)); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == $past(count) + ONE)); // R2

    AST_RELOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == ALL_ONES && !(wr_en && wr_addr == 2'd1))
        |=> (active == $past(shadow))); // R5

    AST_FULL_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == ALL_ONES && shadow == '0 && cmp_en && pwm_en && !wr_en)
        |=> pwm_o); // R6

    AST_WR_ACTIVE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1) |=> !cmp_en); // R7

    AST_WR_SHADOW_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2) |=> cmp_en); // R7

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_en && pwm_en) |=> !pwm_o); // R8

    AST_WR_COUNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3 && !tick) |=> $stable(count)); // R10
endmodule

bind cmp_pwm_channel cpwm_channel_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .count   (count_q),
    .active  (active_q),
    .shadow  (shadow_q),
    .cmp_en  (cmp_en_q),
    .pwm_en  (pwm_en_q),
    .pwm_o   (pwm_o)
);

// File: tb/cmp_pwm_channel_bench.sv
module cmp_pwm_channel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int PERIOD = 256;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = 2'd0;
    logic [W-1:0] rd_data;
    logic [W-1:0] count_o;
    logic         pwm_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // behavioural reference state
    int m_cnt, m_act, m_shd, m_ce, m_pe, m_out;
    int t_wrap, t_nc, t_tgt, t_hit, t_out, t_act, t_shd, t_ce, t_pe;

    cmp_pwm_channel #(.W(W)) u_cmp_pwm_channel (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .count_o (count_o),
        .pwm_o   (pwm_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_act = 0; m_shd = 0; m_ce = 0; m_pe = 0; m_out = 0;
        end else begin
            t_wrap = (tick && m_cnt == PERIOD - 1);
            t_nc   = tick ? (m_cnt + 1) % PERIOD : m_cnt;
            t_tgt  = t_wrap ? m_shd : m_act;
            t_hit  = tick && (t_nc == t_tgt);
            if (!(m_ce && m_pe)) t_out = 0;
            else if (t_hit)      t_out = 1;
            else if (t_wrap)     t_out = 0;
            else                 t_out = m_out;
            t_act = m_act; t_shd = m_shd; t_ce = m_ce; t_pe = m_pe;
            if (wr_en && wr_addr == 2'd1) t_act = wr_data;
            else if (t_wrap)              t_act = m_shd;
            if (wr_en && wr_addr == 2'd2) t_shd = wr_data;
            if (wr_en && wr_addr == 2'd0) begin
                t_ce = wr_data[0]; t_pe = wr_data[1];
            end else if (wr_en && wr_addr == 2'd1) t_ce = 0;
            else if (wr_en && wr_addr == 2'd2)     t_ce = 1;
            m_cnt = t_nc; m_out = t_out; m_act = t_act;
            m_shd = t_shd; m_ce = t_ce; m_pe = t_pe;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(count_o == m_cnt, "R2 count", count_o, m_cnt);
            chk(pwm_o == m_out, "R3/R4 pwm_o", pwm_o, m_out);
        end
    end

    task automatic wr(input int addr, input int data);
        wr_en = 1'b1; wr_addr = addr[1:0]; wr_data = data[W-1:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int addr, output int val);
        rd_addr = addr[1:0];
        #1;
        val = rd_data;
    endtask

    task automatic wait_count(input int v);
        while (count_o != v) @(negedge clk);
    endtask

    // measures one full period from count 0; optional shadow write at index wr_at
    task automatic measure(input int wr_at, input int wr_val, output int hi);
        wait_count(0);
        hi = 0;
        for (int i = 0; i < PERIOD; i++) begin
            if (pwm_o) hi++;
            if (i == wr_at) begin
                wr_en = 1'b1; wr_addr = 2'd2; wr_data = wr_val[W-1:0];
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic duty_case(input int shd);
        int hi;
        wr(2, shd);
        wait_count(5);
        for (int p = 0; p < 2; p++) begin
            measure(-1, 0, hi);
            chk(hi == PERIOD - shd, (shd == 0) ? "R6 R9 full duty" : "R9 duty", hi, PERIOD - shd);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int v, hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a, v);
            chk(v == 0, "R1 reset register", v, 0);
        end
        chk(pwm_o == 0, "R1 reset output", pwm_o, 0);

        // R2 no tick, count frozen (also checked every clock)
        repeat (5) @(negedge clk);
        rd(3, v);
        chk(v == 0, "R2 count frozen without tick", v, 0);

        // R7 R10 enable bits via writes
        wr(0, 2);
        rd(0, v);
        chk(v == 2, "R10 mode pwm enable", v, 2);
        wr(2, 8'h80);
        rd(0, v);
        chk(v == 3, "R7 shadow write arms", v, 3);
        rd(2, v);
        chk(v == 8'h80, "R10 shadow readback", v, 8'h80);

        tick = 1'b1;
        duty_case(8'h80);
        duty_case(0);
        duty_case(1);
        duty_case(8'hFF);

        // R5 mid-period shadow write takes effect only next period
        duty_case(8'h40);
        measure(8'h20, 8'hC0, hi);
        chk(hi == PERIOD - 8'h40, "R5 current period unchanged", hi, PERIOD - 8'h40);
        measure(-1, 0, hi);
        chk(hi == PERIOD - 8'hC0, "R5 next period updated", hi, PERIOD - 8'hC0);
        rd(1, v);
        chk(v == 8'hC0, "R5 active reloaded", v, 8'hC0);

        // R10 count writes ignored
        wr(3, 8'h11);
        wr(3, 8'h22);

        // R11 active write on the rollover cycle wins
        wait_count(PERIOD - 1);
        wr(1, 8'h33);
        rd(1, v);
        chk(v == 8'h33, "R11 active write beats reload", v, 8'h33);
        rd(0, v);
        chk(v == 2, "R7 active write disarms", v, 2);

        // R8 0% duty while disarmed
        measure(-1, 0, hi);
        chk(hi == 0, "R8 zero duty disarmed", hi, 0);
        rd(1, v);
        chk(v == 8'hC0, "R5 reload while disarmed", v, 8'hC0);

        // R8 compare enabled but pwm disabled
        wr(0, 1);
        measure(-1, 0, hi);
        chk(hi == 0, "R8 zero duty pwm off", hi, 0);

        // gated tick pattern, compared every clock by the model
        wr(0, 3);
        wr(2, 8'h10);
        for (int c = 0; c < 1500; c++) begin
            tick = ((c % 3) != 0);
            @(negedge clk);
        end
        tick = 1'b0;
        rd(3, v);
        repeat (4) @(negedge clk);
        chk(count_o == v, "R2 count holds with tick low", count_o, v);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule